// File: doc/BRIEF.md
# Quarter-Rate Look-Ahead Decision Selector

This block is the digital back end of a two-tap look-ahead decision feedback equalizer that runs at a quarter of the line rate. Each slow clock cycle carries four interleaved line bits, one per sampling phase. For every phase, four slicers have already compared the received signal against thresholds that assume one of the four possible pairs of earlier bits, so each phase offers four tentative bits. The selector resolves which tentative bit is real by using the two bits decided just before it.

The selection chains through the cycle. The earliest lane draws on the last two bits of the previous cycle, the next lane on the last bit of the previous cycle and the earliest lane of this cycle, and each later lane on the two lanes before it. The four decisions are registered as the recovered parallel word. The last two are kept as history for the next cycle and are also exported for an eye or adaptation monitor further down the chain.

Top module: `lads_selector`

## Requirements
- R1: While rstN is low, dataOut, histOut and outValid are all zero.
- R2: outValid is low from reset until the first rising clock edge with rstN high, and high at every edge after that until the next reset.
- R3: samples holds LANES groups of 2^HIST bits. Lane p uses bits samples[p*2^HIST +: 2^HIST], and candidate index c within a group assumes bit 0 of c as the line bit one before that lane and bit 1 of c as the bit two before it.
- R4: The earliest lane (lane 0) picks its candidate from the two bits last decided in the previous cycle. In the first cycle after reset, that history is 00.
- R5: Lane 1 picks its candidate from the lane 0 decision of the same cycle as the bit one back and the last bit of the previous cycle as the bit two back.
- R6: Every lane from 2 upward picks its candidate from the two lanes just before it in the same cycle.
- R7: The decisions made from the samples present before a rising edge appear on dataOut after that edge, with lane 0 (the earliest bit in line order) in dataOut[0].
- R8: After each edge, histOut[0] equals dataOut[LANES-1] (most recent bit) and histOut[1] equals dataOut[LANES-2].
- R9: When the candidates come from slicing a received signal with two postcursors, dataOut reproduces the transmitted bit stream, matching a full-rate two-tap decision feedback equalizer.
- R10: A reset in the middle of a run clears the history, so the first cycle after it again starts from history 00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Quarter-rate clock |
| rstN | input | 1 | Asynchronous active-low reset |
| samples | input | LANES*2^HIST | Sliced tentative bits, grouped by lane, then by assumed history |
| dataOut | output | LANES | Decided bits, lane 0 earliest |
| histOut | output | HIST | Decided history, bit 0 most recent |
| outValid | output | 1 | High once the first word has been captured |

## Verification
The bench builds the selector with its defaults: four lanes and a two-bit history, so sixteen tentative bits per cycle. With these values, the bench reaches every candidate index on every lane, and the carry of history from lane 3 into lanes 0 and 1 of the next cycle. A channel model with two postcursors large enough to flip the wrong candidates makes a history mistake in any lane appear as a stream error. Directed words where only one candidate index is set per lane pin down the order of the index bits.

// File: rtl/lads_pkg.sv
package lads_pkg;

  // strobes from the control to the datapath
  typedef struct packed {
    logic seedHist;  // use an all-zero history for lane 0 this cycle
    logic advance;   // capture decisions and history at this edge
  } lads_strobe_t;

endpackage

// File: rtl/lads_lane_mux.sv
module lads_lane_mux #(
  parameter int HIST = 2
) (
  input  logic [(1<<HIST)-1:0] cand,
  input  logic [HIST-1:0]      sel,
  output logic                 bitOut
);

  // sel bit 0: bit one back, sel bit 1: bit two back
  assign bitOut = cand[sel];

endmodule

// File: rtl/lads_control.sv
module lads_control
  import lads_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  output lads_strobe_t strb,
  output logic         outValid
);

  typedef enum logic {ST_SEED, ST_RUN} state_t;
  state_t state;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_SEED;
      outValid <= 1'b0;
    end else begin
      state    <= ST_RUN;
      outValid <= 1'b1;
    end
  end

  always_comb begin
    strb.seedHist = (state == ST_SEED);
    strb.advance  = 1'b1;
  end

  // R2: valid is raised by the first capture edge and then stays high
  p_valid_rise_r2: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> outValid);

endmodule

// File: rtl/lads_datapath.sv
module lads_datapath
  import lads_pkg::*;
#(
  parameter int LANES = 4,
  parameter int HIST  = 2
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  lads_strobe_t                strb,
  input  logic [LANES*(1<<HIST)-1:0]  samples,
  output logic [LANES-1:0]            dataOut,
  output logic [HIST-1:0]             histOut
);

  localparam int CANDS = 1 << HIST;
  localparam int CHAIN = HIST + LANES;

  logic [HIST-1:0]  histReg;
  logic [HIST-1:0]  histUse;
  logic [CHAIN-1:0] chain;     // oldest bit at index 0
  logic [LANES-1:0] decision;

  assign histUse = strb.seedHist ? '0 : histReg;

  for (genvar j = 0; j < HIST; j++) begin : g_seed
    assign chain[HIST-1-j] = histUse[j];
  end

  // ripple of selections through the lanes, earliest lane first
  for (genvar p = 0; p < LANES; p++) begin : g_lane
    logic [HIST-1:0] sel;
    for (genvar j = 0; j < HIST; j++) begin : g_sel
      assign sel[j] = chain[HIST+p-1-j];
    end
    lads_lane_mux #(.HIST(HIST)) u_mux (
      .cand   (samples[p*CANDS +: CANDS]),
      .sel    (sel),
      .bitOut (decision[p])
    );
    assign chain[HIST+p] = decision[p];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dataOut <= '0;
      histReg <= '0;
    end else if (strb.advance) begin
      dataOut <= decision;
      for (int j = 0; j < HIST; j++) histReg[j] <= decision[LANES-1-j];
    end
  end

  assign histOut = histReg;

  // ---------------- checks against the previous cycle ----------------
  logic [LANES*CANDS-1:0] sampPrev;
  logic [HIST-1:0]        histPrev;
  logic                   chkArmed;
  logic [CHAIN-1:0]       chkChain;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sampPrev <= '0;
      histPrev <= '0;
      chkArmed <= 1'b0;
    end else begin
      sampPrev <= samples;
      histPrev <= histUse;
      chkArmed <= 1'b1;
    end
  end

  always_comb begin
    for (int j = 0; j < HIST; j++) chkChain[HIST-1-j] = histPrev[j];
    chkChain[HIST +: LANES] = dataOut;
  end

  for (genvar p = 0; p < LANES; p++) begin : g_chk
    logic [HIST-1:0] idxChk;
    for (genvar j = 0; j < HIST; j++) begin : g_idx
      assign idxChk[j] = chkChain[HIST+p-1-j];
    end
    if (p == 0) begin : g_first
      // R4: lane 0 follows the history carried over from the last cycle
      p_lane0_hist_r4: assert property (@(posedge clk) disable iff (!rstN)
        chkArmed |-> dataOut[0] == sampPrev[idxChk]);
    end else begin : g_rest
      // R5, R6: later lanes follow decisions of the same cycle
      p_lane_pick_r6: assert property (@(posedge clk) disable iff (!rstN)
        chkArmed |-> dataOut[p] == sampPrev[p*CANDS + int'(idxChk)]);
    end
  end

  // R8: exported history is the tail of the captured word
  for (genvar j = 0; j < HIST; j++) begin : g_tail
    p_hist_tail_r8: assert property (@(posedge clk) disable iff (!rstN)
      chkArmed |-> histOut[j] == dataOut[LANES-1-j]);
  end

endmodule

// File: rtl/lads_selector.sv
module lads_selector
  import lads_pkg::*;
#(
  parameter int LANES = 4,
  parameter int HIST  = 2
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic [LANES*(1<<HIST)-1:0]  samples,
  output logic [LANES-1:0]            dataOut,
  output logic [HIST-1:0]             histOut,
  output logic                        outValid
);

  lads_strobe_t strb;

  lads_control u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .outValid (outValid)
  );

  lads_datapath #(.LANES(LANES), .HIST(HIST)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .samples (samples),
    .dataOut (dataOut),
    .histOut (histOut)
  );

  // R1: reset clears every output
  p_reset_clear_r1: assert property (@(posedge clk)
    !rstN |=> (!outValid && histOut == '0 && dataOut == '0));

endmodule

// File: tb/lads_selector_test.sv
module lads_selector_test;

  localparam int PERIOD = 10;
  localparam int LANES  = 4;
  localparam int HIST   = 2;
  localparam int NS     = LANES * (1 << HIST);

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [NS-1:0] samples = '0;
  logic [LANES-1:0] dataOut;
  logic [HIST-1:0]  histOut;
  logic             outValid;

  int checks = 0;
  int errors = 0;
  logic [1:0] mHist = 2'b00;   // bit 0 most recent
  logic tx1 = 1'b0, tx2 = 1'b0; // channel history: one and two bits back

  lads_selector #(.LANES(LANES), .HIST(HIST)) uut (
    .clk(clk), .rstN(rstN), .samples(samples),
    .dataOut(dataOut), .histOut(histOut), .outValid(outValid)
  );

  always #(PERIOD/2) clk = ~clk;

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string req);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // serial reference: each bit chooses among its four candidates
  function automatic logic [LANES-1:0] refSelect(input logic [NS-1:0] v, input logic [1:0] h);
    logic [LANES-1:0] o;
    logic [1:0] hh = h;
    for (int p = 0; p < LANES; p++) begin
      o[p] = v[p*4 + int'(hh)];
      hh = {hh[0], o[p]};
    end
    return o;
  endfunction

  function automatic int sg(input logic b);
    return b ? 1 : -1;
  endfunction

  // drive a word at a falling edge, check at the next falling edge
  task automatic runVec(input logic [NS-1:0] v, input bit hasTx,
                        input logic [LANES-1:0] tx, input string tag);
    logic [LANES-1:0] ev;
    samples = v;
    ev = refSelect(v, mHist);
    @(negedge clk);
    check(32'(dataOut), 32'(ev), {tag, " R3 R4 R5 R6 R7"});
    check(32'(histOut), 32'({ev[LANES-2], ev[LANES-1]}), "R8");
    check(32'(outValid), 32'd1, "R2");
    if (hasTx) check(32'(dataOut), 32'(tx), "R9");
    mHist = {ev[LANES-2], ev[LANES-1]};
  endtask

  // candidates from a channel with main cursor 8 and postcursors 3 and 2
  task automatic runChannel();
    logic [LANES-1:0] bits;
    logic [NS-1:0] v;
    bits = LANES'($urandom);
    for (int p = 0; p < LANES; p++) begin
      int rx;
      rx = 8*sg(bits[p]) + 3*sg(tx1) + 2*sg(tx2) + int'($urandom_range(4)) - 2;
      for (int c = 0; c < 4; c++) begin
        v[p*4+c] = (rx - 3*sg(c[0]) - 2*sg(c[1])) > 0;
      end
      tx2 = tx1;
      tx1 = bits[p];
    end
    runVec(v, 1'b1, bits, "R9");
  endtask

  task automatic checkReset(input string tag);
    check(32'(dataOut), 32'd0, {tag, " R1"});
    check(32'(histOut), 32'd0, {tag, " R1"});
    check(32'(outValid), 32'd0, {tag, " R1"});
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    checkReset("R1");
    rstN = 1'b1;
    #1 check(32'(outValid), 32'd0, "R2 before first edge");
    // directed words: one candidate index set per lane
    runVec(16'h8888, 1'b0, '0, "R3 idx3");
    runVec(16'h2222, 1'b0, '0, "R3 idx1");
    runVec(16'hFFFF, 1'b0, '0, "R4 ones");
    runVec(16'h4444, 1'b0, '0, "R3 idx2");
    runVec(16'hAAAA, 1'b0, '0, "R5 follow");
    runVec(16'h5555, 1'b0, '0, "R6 invert");
    runVec(16'h0000, 1'b0, '0, "R4 zeros");
    runVec(16'h1111, 1'b0, '0, "R3 idx0");
    for (int i = 0; i < 300; i++) runVec(NS'($urandom), 1'b0, '0, "rand");
    // reset in the middle of a run
    @(negedge clk) begin end
    samples = NS'($urandom);
    rstN = 1'b0;
    #1 checkReset("R10");
    @(negedge clk);
    checkReset("R10");
    rstN = 1'b1;
    mHist = 2'b00;
    tx1 = 1'b0;
    tx2 = 1'b0;
    runVec(16'h8421, 1'b0, '0, "R10 seed");
    mHist = {dataOut[LANES-2], dataOut[LANES-1]};
    tx1 = dataOut[LANES-1];
    tx2 = dataOut[LANES-2];
    for (int i = 0; i < 400; i++) runChannel();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(PERIOD * 200000);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule